// File: doc/BRIEF.md
# Vector-Scalar GHASH Multiply Engine

This unit runs the GHASH step of GCM over a run of 128-bit element groups that all share one hash key. For each group it either folds a data block into the running hash and multiplies by the key, or only multiplies the running hash by the key. One start pulse launches a whole operation. The caller supplies an element count and a start element, both counted in 32-bit elements. The caller also gives the register numbers of the destination group and of the key, which lets the unit reject a destination that would overwrite the key while the operation is still running.

The key is captured once when the operation starts and stays in the unit from then on. A working copy is loaded from that captured key at the start of every group, so changes made while one group is processed never reach the next group. The unit reads groups one at a time through an index output. It puts each product out for one cycle, tagged with its group index, and pulses done once the last product has been written.

The multiply is bit-serial and takes 128 cycles per group. Each group costs 129 cycles in total.

Top module: `ghash_vs_engine`

## Requirements
- R1: After reset, res_valid, done and illegal are all low, and no product is put out until an operation is started.
- R2: Field arithmetic works on each 128-bit word after its bits have been reversed inside every byte (byte k is bits 8k+7..8k). After that reversal, bit i is the coefficient of x^i, and the field is reduced by x^128 + x^7 + x^2 + x + 1. With mul_only = 0, the product is rev(rev(acc) XOR rev(dat) times rev(H)), where rev is that per-byte reversal.
- R3: With mul_only = 1, the product is rev(rev(acc) times rev(H)), and dat_in has no effect on it.
- R4: H is taken from key_in in the cycle start is accepted. Every group of the operation uses that same H, and key_in changes after the start have no effect.
- R5: Groups are processed in ascending order, from elem_start/4 up to elem_cnt/4 - 1. rd_idx shows the group being read, and res_idx tags each product with its group.
- R6: The product of the j-th processed group (j counted from 0) appears 129*(j+1) cycles after the accepted start edge. res_valid is high for exactly one cycle per product.
- R7: done is a one-cycle pulse in the cycle after the last product. If elem_start >= elem_cnt, no products are put out and done comes in the second cycle after the start edge.
- R8: If elem_cnt or elem_start is not a multiple of 4, illegal rises in the cycle after start, no products are put out, and done pulses one cycle later. illegal holds until the next accepted start.
- R9: If key_reg lies within dst_reg .. dst_reg+dst_len-1, the operation is flagged illegal in the same way as in R8. A key register just past the end of the destination group is legal.
- R10: A start pulse that arrives while an operation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| mul_only | input | 1 | 1: multiply only; 0: fold data, then multiply |
| elem_cnt | input | CNTW | End element count (exclusive) |
| elem_start | input | CNTW | First element index |
| dst_reg | input | RW | First register of the destination group |
| dst_len | input | LW | Number of registers in the destination group |
| key_reg | input | RW | Register holding the key group |
| key_in | input | 128 | Key group, captured at start |
| rd_idx | output | CNTW-2 | Index of the group being read |
| acc_in | input | 128 | Accumulator for group rd_idx |
| dat_in | input | 128 | Data block for group rd_idx |
| res_valid | output | 1 | Product strobe |
| res_idx | output | CNTW-2 | Group index of the product |
| res_data | output | 128 | Product |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Reserved case detected |

## Verification
If the start is sampled at edge E, illegal is due right after E. Group j's product is due right after edge E+129*(j+1), and done right after edge E+129*n+1 for n groups (E+1 when n is zero). At each start the bench enters these due cycles into a schedule keyed by cycle number. It then compares every output against that schedule on every falling edge, so a product that arrives one cycle early or late, or any stray strobe, is seen as a mismatch.

// File: rtl/ghash_vs_engine.sv
module ghash_vs_engine #(
  parameter int CNTW = 8,
  parameter int RW   = 5,
  parameter int LW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            mul_only,
  input  logic [CNTW-1:0] elem_cnt,
  input  logic [CNTW-1:0] elem_start,
  input  logic [RW-1:0]   dst_reg,
  input  logic [LW-1:0]   dst_len,
  input  logic [RW-1:0]   key_reg,
  input  logic [127:0]    key_in,
  output logic [CNTW-3:0] rd_idx,
  input  logic [127:0]    acc_in,
  input  logic [127:0]    dat_in,
  output logic            res_valid,
  output logic [CNTW-3:0] res_idx,
  output logic [127:0]    res_data,
  output logic            done,
  output logic            illegal
);
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_MUL, S_FIN} st_t;

  function automatic logic [127:0] brev8(input logic [127:0] v);
    logic [127:0] r;
    for (int b = 0; b < 16; b++)
      for (int k = 0; k < 8; k++)
        r[b*8+k] = v[b*8+7-k];
    return r;
  endfunction

  st_t             st;
  logic [127:0]    key_r, s_r, z_r, h_r;
  logic            mode_r;
  logic [CNTW-3:0] idx, last_idx;
  logic [6:0]      bitc;

  logic [RW:0] dst_end;
  logic        misalign, overlap, empty;
  logic [127:0] h_nx, z_nx;

  assign dst_end  = {1'b0, dst_reg} + (RW+1)'(dst_len);
  assign misalign = (|elem_cnt[1:0]) | (|elem_start[1:0]);
  assign overlap  = (key_reg >= dst_reg) && ({1'b0, key_reg} < dst_end);
  assign empty    = elem_start >= elem_cnt;
  assign h_nx     = {h_r[126:0], 1'b0} ^ (h_r[127] ? 128'h87 : 128'h0);
  assign z_nx     = s_r[0] ? (z_r ^ h_r) : z_r;
  assign rd_idx   = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      key_r <= '0; s_r <= '0; z_r <= '0; h_r <= '0;
      mode_r <= 1'b0; idx <= '0; last_idx <= '0; bitc <= '0;
      res_valid <= 1'b0; res_idx <= '0; res_data <= '0;
      done <= 1'b0; illegal <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      done      <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          illegal  <= misalign | overlap;
          key_r    <= brev8(key_in);
          mode_r   <= mul_only;
          idx      <= elem_start[CNTW-1:2];
          last_idx <= elem_cnt[CNTW-1:2] - 1'b1;
          st       <= (misalign | overlap | empty) ? S_FIN : S_LOAD;
        end
        S_LOAD: begin
          s_r  <= brev8(acc_in) ^ (mode_r ? 128'h0 : brev8(dat_in));
          z_r  <= '0;
          h_r  <= key_r;
          bitc <= '0;
          st   <= S_MUL;
        end
        S_MUL: begin
          s_r  <= s_r >> 1;
          z_r  <= z_nx;
          h_r  <= h_nx;
          bitc <= bitc + 1'b1;
          if (bitc == 7'd127) begin
            res_valid <= 1'b1;
            res_data  <= brev8(z_nx);
            res_idx   <= idx;
            if (idx == last_idx) st <= S_FIN;
            else begin
              idx <= idx + 1'b1;
              st  <= S_LOAD;
            end
          end
        end
        default: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_illegal_silent: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !res_valid);
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && $past(st) == S_MUL) |-> idx == $past(idx) + 1'b1);
  a_r4_key_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE) |-> $stable(key_r));
  a_r10_busy_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MUL && bitc != 7'd127) |=> st == S_MUL);
endmodule

// File: tb/ghash_vs_engine_tb.sv
module ghash_vs_engine_tb;
  logic clk = 0, rst_n = 0, start = 0, mul_only = 0;
  logic [7:0] elem_cnt = 0, elem_start = 0;
  logic [4:0] dst_reg = 0, key_reg = 0;
  logic [3:0] dst_len = 1;
  logic [127:0] key_in = 0, acc_in, dat_in, res_data;
  logic [5:0] rd_idx, res_idx;
  logic res_valid, done, illegal;

  logic [127:0] acc_mem [64];
  logic [127:0] dat_mem [64];
  assign acc_in = acc_mem[rd_idx];
  assign dat_in = dat_mem[rd_idx];

  ghash_vs_engine u_dut (.clk(clk), .rst_n(rst_n), .start(start), .mul_only(mul_only),
    .elem_cnt(elem_cnt), .elem_start(elem_start), .dst_reg(dst_reg), .dst_len(dst_len),
    .key_reg(key_reg), .key_in(key_in), .rd_idx(rd_idx), .acc_in(acc_in), .dat_in(dat_in),
    .res_valid(res_valid), .res_idx(res_idx), .res_data(res_data), .done(done),
    .illegal(illegal));

  always #4 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0;
  string cur_req = "R1";
  logic [127:0] exp_res [int];
  int           exp_gi  [int];
  bit           exp_dn  [int];
  bit           ill_at  [int];
  bit           exp_ill = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [127:0] rev(input logic [127:0] v);
    logic [127:0] r;
    for (int k = 0; k < 128; k++) r[(k/8)*8 + 7 - (k%8)] = v[k];
    return r;
  endfunction

  function automatic logic [127:0] gf_ref(input logic [127:0] a, input logic [127:0] b);
    logic [254:0] p = '0;
    for (int i = 0; i < 128; i++) if (a[i]) p ^= (255'(b) << i);
    for (int d = 254; d >= 128; d--)
      if (p[d]) begin
        p[d] = 1'b0;
        p[d-121] ^= 1'b1; p[d-126] ^= 1'b1; p[d-127] ^= 1'b1; p[d-128] ^= 1'b1;
      end
    return p[127:0];
  endfunction

  task automatic check(input bit ok, input string what, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s cycle %0d: got %h expected %h", cur_req, what, cyc, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit ev;
    if (ill_at.exists(cyc)) exp_ill = ill_at[cyc];
    ev = exp_res.exists(cyc);
    check(res_valid == ev, "res_valid", 128'(res_valid), 128'(ev));
    if (ev && res_valid) begin
      check(res_data == exp_res[cyc], "res_data", res_data, exp_res[cyc]);
      check(32'(res_idx) == exp_gi[cyc], "res_idx", 128'(res_idx), 128'(exp_gi[cyc]));
    end
    check(done == exp_dn.exists(cyc), "done", 128'(done), 128'(exp_dn.exists(cyc)));
    check(illegal == exp_ill, "illegal", 128'(illegal), 128'(exp_ill));
  end

  // Drives a start and enters the due cycles of every output into the schedule.
  task automatic launch(input bit m, input int es, input int ec, input int dr,
                        input int dl, input int kr, input logic [127:0] key);
    int e, n, ill;
    @(negedge clk);
    mul_only = m; elem_start = 8'(es); elem_cnt = 8'(ec);
    dst_reg = 5'(dr); dst_len = 4'(dl); key_reg = 5'(kr); key_in = key; start = 1;
    e = cyc + 1;
    ill = ((es % 4) != 0 || (ec % 4) != 0 || (kr >= dr && kr < dr + dl)) ? 1 : 0;
    n = (ill != 0 || es >= ec) ? 0 : (ec - es) / 4;
    ill_at[e] = ill[0];
    for (int j = 0; j < n; j++) begin
      int g = es / 4 + j;
      logic [127:0] s = m ? rev(acc_mem[g]) : (rev(acc_mem[g]) ^ rev(dat_mem[g]));
      exp_res[e + 129*(j+1)] = rev(gf_ref(s, rev(key)));
      exp_gi[e + 129*(j+1)]  = g;
    end
    exp_dn[e + 129*n + 1] = 1'b1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      acc_mem[i] = {$urandom, $urandom, $urandom, $urandom};
      dat_mem[i] = {$urandom, $urandom, $urandom, $urandom};
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    check(res_valid == 0 && done == 0 && illegal == 0, "reset outputs",
          {res_valid, done, illegal}, 128'h0);
    idle(3);

    // R2: key rev(H)=1 makes the product equal the folded input
    cur_req = "R2";
    launch(0, 0, 4, 16, 1, 2, 128'h80);
    idle(135);
    cur_req = "R2";
    launch(0, 4, 8, 16, 1, 2, {$urandom, $urandom, $urandom, $urandom});
    idle(135);

    // R4 R5: several groups, key_in disturbed after start (no drift)
    cur_req = "R4 R5 R6";
    launch(0, 8, 20, 20, 4, 3, 128'h0123456789abcdeffedcba9876543210);
    key_in = ~key_in;
    idle(400);

    // R3: multiply only, data ignored
    cur_req = "R3";
    launch(1, 12, 20, 24, 2, 1, 128'hdeadbeef00112233445566778899aabb);
    dat_mem[3] = ~dat_mem[3];
    dat_mem[4] = ~dat_mem[4];
    idle(265);

    // R7: empty range
    cur_req = "R7";
    launch(0, 12, 12, 16, 1, 2, 128'h5);
    idle(5);

    // R8: misaligned count, then misaligned start
    cur_req = "R8";
    launch(0, 0, 6, 16, 1, 2, 128'h5);
    idle(5);
    launch(0, 2, 8, 16, 1, 2, 128'h5);
    idle(5);

    // R9: overlap at last register of destination, then key just past the end
    cur_req = "R9";
    launch(0, 0, 4, 4, 4, 7, 128'h9);
    idle(5);
    launch(0, 16, 20, 4, 4, 8, 128'h77ff);
    idle(135);

    // R10: start during a run is ignored
    cur_req = "R10";
    launch(0, 20, 28, 8, 1, 0, 128'h1234);
    idle(50);
    start = 1; elem_start = 8'd1; key_in = '1;
    @(negedge clk);
    start = 0;
    idle(220);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired (R6): got hang expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule